// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the device side of a two-wire serial EEPROM. It sits on a system clock that runs much faster than the bus clock. It samples the SCL and SDA pins and drives SDA only by pulling it low through an output enable. It holds an internal byte array and an address counter. It recognises start and stop conditions and decodes the device header byte. It serves byte and page writes, reads from the current counter position, random reads and sequential reads.

After a stop that ends a write carrying data, the block runs a self-timed write cycle of a fixed number of system clocks. For that whole cycle it stays silent on its own header. A master can therefore poll with headers until one is acknowledged, rather than wait out the worst-case time.

The counter behaves differently on the two paths. A write wraps it inside the current page. A read wraps it across the whole array.

Top module: `eep_i2c_slave`

## Requirements
- R1: Header byte layout, sent MSB first: bits 7..4 must be 1010 and bits 3..1 must equal the DEV_SEL parameter (default 000). Bit 0 selects the direction, 1 for read and 0 for write. A header that does not match gets no acknowledge, and SDA stays released until the next start or stop.
- R2: A stop that follows at least one complete data byte starts a write cycle lasting TWR_CLKS system clocks. During that cycle a matching header is not acknowledged, and SDA stays released in the ninth clock.
- R3: Once the write cycle has ended, a matching header is acknowledged and the requested transfer goes ahead normally.
- R4: After a write header, the next ceil(log2(MEM_BYTES)/8) bytes are the word address, MSB first, and they load the counter. Each later data byte is acknowledged, stored at the counter, and advances the counter.
- R5: A write to the last location of a page moves the counter to the first location of the same page. Later data bytes therefore overwrite the start of that page.
- R6: A read header with no address phase is acknowledged, and the block then shifts out the byte at the counter, MSB first, changing SDA only while SCL is low.
- R7: Every byte sent advances the counter, and the counter goes from the last array location to 0. While the master acknowledges, further bytes follow in order.
- R8: A random read is a write header, the word address, a repeated start and then a read header. It returns the byte at the given address and starts no write cycle.
- R9: A master that does not acknowledge in the ninth clock of a read ends the read. The block then releases SDA and drives nothing until the next start or stop.
- R10: After reset, SDA is released, the counter is 0 and no write cycle is running, so the first matching header is acknowledged.
- R11: A stop that comes after only the address bytes, or in the middle of a data byte, starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level, wired-AND of all drivers |
| sda_oe | output | 1 | When 1, the block pulls SDA low |

## Verification
Each pin passes through two synchroniser flops and one edge register before the controller sees it, and the output enable is itself a flop. An acknowledge or a data bit therefore appears on SDA about four system clocks after the SCL falling edge that triggers it. The bench holds each SCL phase for 12 clocks and samples SDA in the middle of the high phase, well after that point. The write cycle starts a few clocks after the SDA rise of the stop condition and lasts TWR_CLKS clocks. The bench checks that the first header poll after a write is refused, then polls header by header and checks that an acknowledge arrives within a bounded number of polls.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACKOUT,
        PH_TX,
        PH_ACKIN,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_ADDR,
        RX_DATA
    } rxkind_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic hdr_match(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_p;
    logic       sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_p  <= scl_ff[1];
            sda_p  <= sda_ff[1];
        end
    end

    always_comb begin
        ev.rise  = scl_ff[1] & ~scl_p;
        ev.fall  = ~scl_ff[1] & scl_p;
        ev.start = scl_ff[1] & scl_p & sda_p & ~sda_ff[1];
        ev.stop  = scl_ff[1] & scl_p & ~sda_p & sda_ff[1];
        ev.sda   = sda_ff[1];
    end

endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
    parameter int TWR_CLKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start_twr,
    output logic busy
);

    localparam int TW = $clog2(TWR_CLKS + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start_twr) begin
            cnt <= TW'(TWR_CLKS);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    // R2
    busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_twr));

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int MEM_BYTES = 256,
    localparam int ADDR_W = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int         MEM_BYTES  = 256,
    parameter int         PAGE_BYTES = 16,
    parameter logic [2:0] DEV_SEL    = 3'b000,
    localparam int ADDR_W = $clog2(MEM_BYTES),
    localparam int PG_W   = $clog2(PAGE_BYTES),
    localparam int AB     = (ADDR_W + 7) / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              busy,
    input  logic [7:0]        rd_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              start_twr,
    output logic              sda_oe
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MEM_BYTES - 1);
    localparam int AIW = (AB > 1) ? $clog2(AB) : 1;

    phase_e            phase;
    rxkind_e           kind;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        txsh;
    logic [ADDR_W-1:0] ptr;
    logic [AIW-1:0]    addr_idx;
    logic              data_seen;
    logic              go_tx;
    logic              m_ack;

    logic [ADDR_W+7:0] addr_cat;
    logic [ADDR_W-1:0] page_next;
    logic [ADDR_W-1:0] arr_next;
    logic              byte_in_done;
    logic              byte_out_done;

    always_comb begin
        addr_cat      = {ptr, shreg};
        page_next     = {ptr[ADDR_W-1:PG_W], ptr[PG_W-1:0] + 1'b1};
        arr_next      = (ptr == LAST) ? '0 : ptr + 1'b1;
        byte_in_done  = (phase == PH_RX) && ev.fall && (bitcnt == 4'd8);
        byte_out_done = (phase == PH_TX) && ev.fall && (bitcnt == 4'd8);
        mem_we        = byte_in_done && (kind == RX_DATA) && !ev.start && !ev.stop;
        mem_addr      = ptr;
        mem_wdata     = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            kind      <= RX_DEV;
            bitcnt    <= '0;
            shreg     <= '0;
            txsh      <= '0;
            ptr       <= '0;
            addr_idx  <= '0;
            data_seen <= 1'b0;
            go_tx     <= 1'b0;
            m_ack     <= 1'b0;
            start_twr <= 1'b0;
            sda_oe    <= 1'b0;
        end else begin
            start_twr <= 1'b0;
            if (ev.stop) begin
                phase     <= PH_IDLE;
                sda_oe    <= 1'b0;
                start_twr <= data_seen;
                data_seen <= 1'b0;
            end else if (ev.start) begin
                phase  <= PH_RX;
                kind   <= RX_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (ev.rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (byte_in_done) begin
                            bitcnt <= '0;
                            case (kind)
                                RX_DEV: begin
                                    if (hdr_match(shreg, DEV_SEL) && !busy) begin
                                        sda_oe <= 1'b1;
                                        phase  <= PH_ACKOUT;
                                        go_tx  <= shreg[0];
                                        if (!shreg[0]) begin
                                            kind     <= RX_ADDR;
                                            addr_idx <= '0;
                                        end
                                    end else begin
                                        phase <= PH_HOLD;
                                    end
                                end
                                RX_ADDR: begin
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACKOUT;
                                    go_tx  <= 1'b0;
                                    ptr    <= addr_cat[ADDR_W-1:0];
                                    if (addr_idx == AIW'(AB - 1)) begin
                                        kind <= RX_DATA;
                                    end else begin
                                        addr_idx <= addr_idx + 1'b1;
                                    end
                                end
                                default: begin
                                    sda_oe    <= 1'b1;
                                    phase     <= PH_ACKOUT;
                                    go_tx     <= 1'b0;
                                    ptr       <= page_next;
                                    data_seen <= 1'b1;
                                end
                            endcase
                        end
                    end
                    PH_ACKOUT: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (go_tx) begin
                                phase  <= PH_TX;
                                txsh   <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                phase  <= PH_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.rise && bitcnt < 4'd8) begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (byte_out_done) begin
                            sda_oe <= 1'b0;
                            phase  <= PH_ACKIN;
                            ptr    <= arr_next;
                            m_ack  <= 1'b0;
                        end else if (ev.fall) begin
                            sda_oe <= ~txsh[6];
                            txsh   <= {txsh[6:0], 1'b0};
                        end
                    end
                    PH_ACKIN: begin
                        if (ev.rise) begin
                            m_ack <= ~ev.sda;
                        end
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (m_ack) begin
                                phase  <= PH_TX;
                                txsh   <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                phase <= PH_HOLD;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // R5
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (ptr[ADDR_W-1:PG_W] == $past(ptr[ADDR_W-1:PG_W])));

    // R7
    array_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_out_done && !ev.start && !ev.stop && ptr == LAST) |=> (ptr == '0));

    // R2
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_in_done && kind == RX_DEV && busy && !ev.start && !ev.stop) |=> !sda_oe);

    // R9
    ackin_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACKIN || phase == PH_HOLD) |-> !sda_oe);

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int         MEM_BYTES  = 256,
    parameter int         PAGE_BYTES = 16,
    parameter int         TWR_CLKS   = 200,
    parameter logic [2:0] DEV_SEL    = 3'b000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int ADDR_W = $clog2(MEM_BYTES);

    bus_ev_t           ev;
    logic              busy;
    logic              start_twr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;

    eep_bus_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eep_ctrl #(
        .MEM_BYTES  (MEM_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .DEV_SEL    (DEV_SEL)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .busy      (busy),
        .rd_byte   (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .start_twr (start_twr),
        .sda_oe    (sda_oe)
    );

    eep_array #(
        .MEM_BYTES (MEM_BYTES)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    eep_write_timer #(
        .TWR_CLKS (TWR_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_twr (start_twr),
        .busy      (busy)
    );

endmodule

// File: tb/eep_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module eep_i2c_slave_tb_top;

    localparam int H = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eep_i2c_slave #(
        .MEM_BYTES  (256),
        .PAGE_BYTES (16),
        .TWR_CLKS   (600),
        .DEV_SEL    (3'b000)
    ) dut_i (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    // {word address, data}
    localparam logic [15:0] VEC [6] = '{
        16'h005A, 16'h01C4, 16'h1033, 16'h7F7E, 16'h80A5, 16'hC30F
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wt(H / 2); sda_m = 1'b1;
        wt(H / 2); scl = 1'b1;
        wt(H);     sda_m = 1'b0;
        wt(H);     scl = 1'b0;
    endtask

    task automatic bus_stop();
        wt(H / 2); sda_m = 1'b0;
        wt(H / 2); scl = 1'b1;
        wt(H);     sda_m = 1'b1;
        wt(H);
    endtask

    task automatic put_bit(input bit b);
        wt(H / 2); sda_m = b;
        wt(H / 2); scl = 1'b1;
        wt(H);     scl = 1'b0;
    endtask

    task automatic get_bit(output bit b);
        wt(H / 2); sda_m = 1'b1;
        wt(H / 2); scl = 1'b1;
        wt(H / 2); b = sda_bus;
        wt(H / 2); scl = 1'b0;
    endtask

    // returns 0 on acknowledge
    task automatic send_byte(input logic [7:0] v, output bit nak);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(nak);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic poll(output bit nak);
        bus_start();
        send_byte(8'hA0, nak);
        bus_stop();
    endtask

    task automatic wait_ready(output int nacks);
        bit nak;
        nacks = 0;
        for (int i = 0; i < 10; i++) begin
            poll(nak);
            if (!nak) break;
            nacks++;
        end
    endtask

    task automatic write_seq(input logic [7:0] a, input logic [7:0] d[], input string req);
        bit nak;
        bus_start();
        send_byte(8'hA0, nak);
        chk(!nak, req, nak, 0);
        send_byte(a, nak);
        chk(!nak, req, nak, 0);
        foreach (d[i]) begin
            send_byte(d[i], nak);
            chk(!nak, req, nak, 0);
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, output logic [7:0] r[]);
        bit nak;
        r = new[n];
        bus_start();
        send_byte(8'hA0, nak);
        send_byte(a, nak);
        bus_start();
        send_byte(8'hA1, nak);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, r[i]);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] v, output bit nak);
        bus_start();
        send_byte(8'hA1, nak);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        bit nak;
        int nn;
        logic [7:0] v;
        logic [7:0] r[];
        logic [7:0] pg[];

        wt(10);
        rst = 1'b0;
        wt(4);

        // R10: released after reset, not busy
        chk(sda_oe == 1'b0, "R10", sda_oe, 0);
        poll(nak);
        chk(!nak, "R10", nak, 0);

        // R1: wrong type code and wrong select field
        bus_start(); send_byte(8'hB0, nak); bus_stop();
        chk(nak, "R1", nak, 1);
        bus_start(); send_byte(8'hA2, nak); bus_stop();
        chk(nak, "R1", nak, 1);

        // R4 / R8: table of single-byte writes read back randomly
        for (int k = 0; k < 6; k++) begin
            write_seq(VEC[k][15:8], '{VEC[k][7:0]}, "R4");
            wait_ready(nn);
            rand_read(VEC[k][15:8], 1, r);
            chk(r[0] == VEC[k][7:0], "R8", r[0], VEC[k][7:0]);
        end

        // R2 / R3: busy refusal then acknowledge
        write_seq(8'h40, '{8'h11}, "R4");
        poll(nak);
        chk(nak, "R2", nak, 1);
        wait_ready(nn);
        chk(nn < 10, "R3", nn, 0);
        rand_read(8'h40, 1, r);
        chk(r[0] == 8'h11, "R3", r[0], 8'h11);

        // R5: page write of 18 bytes from 0x20 wraps within the page
        pg = new[18];
        foreach (pg[i]) pg[i] = 8'(8'h80 + i);
        write_seq(8'h20, pg, "R5");
        wait_ready(nn);
        cur_read(v, nak);
        chk(!nak, "R6", nak, 0);
        chk(v == 8'h82, "R5", v, 8'h82);
        cur_read(v, nak);
        chk(v == 8'h83, "R6", v, 8'h83);
        rand_read(8'h20, 1, r);
        chk(r[0] == 8'h90, "R5", r[0], 8'h90);
        rand_read(8'h21, 1, r);
        chk(r[0] == 8'h91, "R5", r[0], 8'h91);
        rand_read(8'h2F, 1, r);
        chk(r[0] == 8'h8F, "R5", r[0], 8'h8F);

        // R7: sequential read across the end of the array
        write_seq(8'hFE, '{8'hE1, 8'hE2}, "R4");
        wait_ready(nn);
        rand_read(8'hFE, 3, r);
        chk(r[0] == 8'hE1, "R7", r[0], 8'hE1);
        chk(r[1] == 8'hE2, "R7", r[1], 8'hE2);
        chk(r[2] == 8'h5A, "R7", r[2], 8'h5A);
        cur_read(v, nak);
        chk(v == 8'hC4, "R7", v, 8'hC4);

        // R8 / R11: address-only write then stop, no write cycle
        bus_start(); send_byte(8'hA0, nak); send_byte(8'h10, nak); bus_stop();
        poll(nak);
        chk(!nak, "R8", nak, 0);
        // R11: stop inside a data byte
        bus_start(); send_byte(8'hA0, nak); send_byte(8'h10, nak);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        poll(nak);
        chk(!nak, "R11", nak, 0);

        // R9: after master not-acknowledge the slave drives nothing
        bus_start(); send_byte(8'hA0, nak); send_byte(8'h10, nak);
        bus_start(); send_byte(8'hA1, nak);
        recv_byte(1'b0, v);
        chk(v == 8'h33, "R9", v, 8'h33);
        recv_byte(1'b0, v);
        chk(v == 8'hFF, "R9", v, 8'hFF);
        bus_stop();
        chk(sda_oe == 1'b0, "R9", sda_oe, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule